// File: doc/BRIEF.md
# Expensive Key Schedule Sequencer

This block computes the cost-scaled key setup of the bcrypt password hash and the ciphertext stage that follows it. After a start pulse it captures a cost value, a 128-bit salt and a key of 1 to 72 bytes. It loads the cipher state (the P array and four substitution boxes) from built-in constants. It then runs one salted expansion, followed by 2^cost rounds of a key-only expansion and a salt-only expansion, in that order. Finally it encrypts a fixed 24-byte text 64 times and presents the 192-bit ciphertext together with the captured cost and salt. Text encoding of the result is left to the surrounding logic.

A single Blowfish round is evaluated per clock cycle. The P words and the substitution boxes share one register array, so a round's five reads and an expansion's pair writeback need no address arbitration. The number of rounds and the substitution-box index width are parameters. Reduced tables keep long cost settings practical to exercise.

The controller is a state machine with six states:
- IDLE waits for a start pulse, checks the inputs and loads the state.
- MIX folds the key bytes into the P words.
- ENC runs the cipher rounds.
- WRITE stores an expansion block and chains the next one.
- CSTORE chains or captures a ciphertext block.
- DONE raises the done pulse.

The transitions are:
- IDLE→MIX on an accepted start.
- MIX→ENC after the last P word.
- ENC→WRITE or ENC→CSTORE after the last round, depending on the phase.
- WRITE→ENC for the next block or for the ciphertext phase.
- WRITE→MIX for the next expansion.
- CSTORE→ENC while blocks remain.
- CSTORE→DONE after the final capture.
- DONE→IDLE.

Top module: `bcx_keysched`

## Requirements
- R1: After reset, done_o and err_o are 0 and result_o is all zeros.
- R2: A start pulse in IDLE is rejected if cost_i is below 4 or above 31, or if klen_i is 0 or above 72. On rejection, err_o is 1 for exactly the one cycle after the accepting edge, no run starts, done_o stays 0, and result_o, cost_o and salt_o keep their values. A cost of 4 with a valid length raises no error.
- R3: On an accepted start, state word k is loaded with ((k+1)·0x9E3779B9 mod 2^32) XOR 0x243F6A88. The word order is P[0..ROUNDS+1], then box 1, box 2, box 3 and box 4, each with 2^SBOX_IDX entries.
- R4: Each expansion first XORs every P word with a big-endian 32-bit word made of the next four source bytes, taken cyclically from byte 0. For the key source, byte b is key_i[575-8b -: 8] and klen_i bytes are used. For the salt source, byte b is salt_i[127-8b -: 8] and all 16 bytes are used.
- R5: A block encryption runs ROUNDS rounds. Each round computes x = L XOR P[i] and then (L, R) ← (R XOR F(x), x). F(x) = ((S1[a] + S2[b]) XOR S3[c]) + S4[d], where a, b, c and d are the low SBOX_IDX bits of bytes 3 down to 0 of x. The output block is {R XOR P[ROUNDS+1], L XOR P[ROUNDS]}, with the left word in the upper half.
- R6: After the key mix, an expansion encrypts a 64-bit running block that starts at zero. It writes each result over the next two state words in order, starting with P[0]. In the salted expansion only, the block is first XORed with the upper salt half for even-numbered blocks and with the lower salt half for odd-numbered blocks.
- R7: The run is one salted expansion with the key source. It is followed by 2^cost iterations, each made of an unsalted key-source expansion and then an unsalted salt-source expansion.
- R8: The ciphertext blocks are 0x4F7270686561 6E42, 0x65686F6C64657253 and 0x637279446F756274. Each block is encrypted 64 times in succession. The results are placed in result_o, with the first block in bits 191:128.
- R9: done_o rises exactly (1 + 2^(cost+1))·(ROUNDS+2 + NB·(ROUNDS+1)) + 192·(ROUNDS+1) cycles after the accepting edge. Here NB is half the state word count.
- R10: done_o is high for exactly one cycle. cost_o and salt_o show the cost and salt captured at the accepted start.
- R11: A start pulse during a run is ignored. The inputs captured at the accepted start, and the timing of the run, are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled in IDLE |
| cost_i | input | 6 | Cost setting |
| klen_i | input | 7 | Key length in bytes |
| key_i | input | 576 | Key bytes, byte 0 in the top bits |
| salt_i | input | 128 | Salt bytes, byte 0 in the top bits |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejection pulse |
| result_o | output | 192 | Final ciphertext |
| cost_o | output | 6 | Captured cost |
| salt_o | output | 128 | Captured salt |

## Verification
The hash is compared against a bench model for three input patterns, each of which separates a different fault class.
- A one-byte key makes every P word a repeated byte. It exposes errors in the cyclic byte pointer and its wrap.
- A full 72-byte key uses every key byte exactly once. It catches byte-order and offset faults.
- A random mid-length key run at cost 5 tells the iteration count apart from a cost-4 run, through both the result and the exact latency.

Invalid costs and lengths at each edge of the legal range check the rejection path. A start pulse with different inputs in the middle of a run shows whether the captured inputs are protected.

// File: rtl/bcx_pkg.sv
package bcx_pkg;

    localparam int SALT_BYTES = 16;
    localparam int CT_BLOCKS  = 3;
    localparam int CT_REPS    = 64;
    localparam int COST_MIN   = 4;
    localparam int COST_MAX   = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MIX,
        ST_ENC,
        ST_WRITE,
        ST_CSTORE,
        ST_DONE
    } seq_state_e;

    // Constant initial value of state word k
    function automatic logic [31:0] init_word(input logic [31:0] k);
        return ((k + 32'd1) * 32'h9E3779B9) ^ 32'h243F6A88;
    endfunction

    // Fixed plaintext blocks of the ciphertext stage
    function automatic logic [63:0] ct_block(input logic [1:0] idx);
        unique case (idx)
            2'd0:    return 64'h4F72_7068_6561_6E42;
            2'd1:    return 64'h6568_6F6C_6465_7253;
            2'd2:    return 64'h6372_7944_6F75_6274;
            default: return 64'h0;
        endcase
    endfunction

endpackage

// File: rtl/bcx_state_mem.sv
module bcx_state_mem #(
    parameter int ROUNDS   = 16,
    parameter int SBOX_IDX = 8,
    localparam int NP = ROUNDS + 2,
    localparam int SN = 1 << SBOX_IDX,
    localparam int NW = NP + 4 * SN,
    localparam int NB = NW / 2,
    localparam int WW = $clog2(NW),
    localparam int PW = $clog2(NP),
    localparam int BW = $clog2(NB),
    localparam int RW = $clog2(ROUNDS)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                init_i,
    input  logic                mix_we_i,
    input  logic [PW-1:0]       mix_idx_i,
    input  logic [31:0]         mix_word_i,
    input  logic                pair_we_i,
    input  logic [BW-1:0]       pair_idx_i,
    input  logic [63:0]         pair_data_i,
    input  logic [RW-1:0]       p_idx_i,
    output logic [31:0]         p_o,
    output logic [63:0]         p_tail_o,
    input  logic [31:0]         x_i,
    output logic [3:0][31:0]    s_o
);

    logic [31:0] mem_q [NW];

    logic [WW-1:0] mix_addr;
    logic [WW-1:0] pair_addr;
    assign mix_addr  = WW'(mix_idx_i);
    assign pair_addr = WW'({pair_idx_i, 1'b0});

    always_ff @(posedge clk_i) begin
        if (init_i) begin
            for (int i = 0; i < NW; i++) begin
                mem_q[i] <= bcx_pkg::init_word(32'(i));
            end
        end else begin
            if (mix_we_i) begin
                mem_q[mix_addr] <= mem_q[mix_addr] ^ mix_word_i;
            end
            if (pair_we_i) begin
                mem_q[pair_addr]         <= pair_data_i[63:32];
                mem_q[pair_addr + WW'(1)] <= pair_data_i[31:0];
            end
        end
    end

    assign p_o      = mem_q[WW'(p_idx_i)];
    assign p_tail_o = {mem_q[NP-1], mem_q[NP-2]};

    for (genvar j = 0; j < 4; j++) begin : g_sbox_rd
        logic [WW-1:0] s_addr;
        assign s_addr = WW'(NP + j * SN) + WW'(x_i[24-8*j +: SBOX_IDX]);
        assign s_o[j] = mem_q[s_addr];
    end

    AST_ONE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mix_we_i && pair_we_i)); // R6

endmodule

// File: rtl/bcx_round.sv
module bcx_round (
    input  logic [31:0]      l_i,
    input  logic [31:0]      r_i,
    input  logic [31:0]      p_i,
    input  logic [3:0][31:0] s_i,
    output logic [31:0]      x_o,
    output logic [31:0]      l_o,
    output logic [31:0]      r_o
);

    logic [31:0] f_val;

    assign x_o   = l_i ^ p_i;
    assign f_val = ((s_i[0] + s_i[1]) ^ s_i[2]) + s_i[3];
    assign l_o   = r_i ^ f_val;
    assign r_o   = x_o;

endmodule

// File: rtl/bcx_key_fetch.sv
module bcx_key_fetch #(
    parameter int KEY_BYTES = 72,
    localparam int LW = $clog2(KEY_BYTES + 1)
) (
    input  logic                   src_salt_i,
    input  logic [KEY_BYTES*8-1:0] key_i,
    input  logic [127:0]           salt_i,
    input  logic [LW-1:0]          len_i,
    input  logic [LW-1:0]          ptr_i,
    output logic [31:0]            word_o,
    output logic [LW-1:0]          ptr_next_o
);

    logic [LW-1:0] len_eff;
    assign len_eff = src_salt_i ? LW'(bcx_pkg::SALT_BYTES) : len_i;

    always_comb begin
        logic [LW-1:0] p;
        logic [7:0]    kb;
        logic [7:0]    sb;
        p      = ptr_i;
        word_o = '0;
        for (int j = 0; j < 4; j++) begin
            kb     = key_i[(KEY_BYTES - 1 - int'(p)) * 8 +: 8];
            sb     = salt_i[(15 - int'(p[3:0])) * 8 +: 8];
            word_o = {word_o[23:0], src_salt_i ? sb : kb};
            p      = (p == len_eff - LW'(1)) ? '0 : p + LW'(1);
        end
        ptr_next_o = p;
    end

endmodule

// File: rtl/bcx_keysched.sv
module bcx_keysched #(
    parameter int ROUNDS    = 16,
    parameter int SBOX_IDX  = 8,
    parameter int KEY_BYTES = 72,
    localparam int NP = ROUNDS + 2,
    localparam int SN = 1 << SBOX_IDX,
    localparam int NW = NP + 4 * SN,
    localparam int NB = NW / 2,
    localparam int PW = $clog2(NP),
    localparam int BW = $clog2(NB),
    localparam int RW = $clog2(ROUNDS),
    localparam int LW = $clog2(KEY_BYTES + 1),
    localparam int KB = KEY_BYTES * 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [5:0]    cost_i,
    input  logic [LW-1:0] klen_i,
    input  logic [KB-1:0] key_i,
    input  logic [127:0]  salt_i,
    output logic          done_o,
    output logic          err_o,
    output logic [191:0]  result_o,
    output logic [5:0]    cost_o,
    output logic [127:0]  salt_o
);
    import bcx_pkg::*;

    seq_state_e state_q, state_d;

    logic [31:0]   l_q, r_q;
    logic [RW-1:0] rnd_q;
    logic [PW-1:0] widx_q;
    logic [LW-1:0] kptr_q;
    logic [BW-1:0] blk_q;
    logic          salted_q, src_salt_q, ct_q;
    logic [31:0]   iter_q;
    logic [1:0]    cblk_q;
    logic [5:0]    crep_q;
    logic [5:0]    cost_q;
    logic [127:0]  salt_q;
    logic [KB-1:0] key_q;
    logic [LW-1:0] klen_q;
    logic [191:0]  res_q;
    logic          err_q;

    logic          in_ok, accept, mix_last, rnd_last, blk_last, last_expand;
    logic [31:0]   p_rd, x_val, l_nx, r_nx, kword;
    logic [63:0]   p_tail, out_blk, half_nx;
    logic [3:0][31:0] s_val;
    logic [LW-1:0] kptr_nx;

    assign in_ok = (cost_i >= 6'(COST_MIN)) && (cost_i <= 6'(COST_MAX)) &&
                   (klen_i != '0) && (klen_i <= LW'(KEY_BYTES));
    assign accept      = (state_q == ST_IDLE) && start_i && in_ok;
    assign mix_last    = (widx_q == PW'(NP - 1));
    assign rnd_last    = (rnd_q == RW'(ROUNDS - 1));
    assign blk_last    = (blk_q == BW'(NB - 1));
    assign last_expand = !salted_q && src_salt_q && (iter_q == 32'd1);
    assign out_blk     = {r_q ^ p_tail[63:32], l_q ^ p_tail[31:0]};
    assign half_nx     = !salted_q ? 64'h0 : (blk_q[0] ? salt_q[127:64] : salt_q[63:0]);

    bcx_state_mem #(.ROUNDS(ROUNDS), .SBOX_IDX(SBOX_IDX)) mem_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .init_i      (accept),
        .mix_we_i    (state_q == ST_MIX),
        .mix_idx_i   (widx_q),
        .mix_word_i  (kword),
        .pair_we_i   (state_q == ST_WRITE),
        .pair_idx_i  (blk_q),
        .pair_data_i (out_blk),
        .p_idx_i     (rnd_q),
        .p_o         (p_rd),
        .p_tail_o    (p_tail),
        .x_i         (x_val),
        .s_o         (s_val)
    );

    bcx_round round_i (
        .l_i (l_q),
        .r_i (r_q),
        .p_i (p_rd),
        .s_i (s_val),
        .x_o (x_val),
        .l_o (l_nx),
        .r_o (r_nx)
    );

    bcx_key_fetch #(.KEY_BYTES(KEY_BYTES)) kf_i (
        .src_salt_i (src_salt_q),
        .key_i      (key_q),
        .salt_i     (salt_q),
        .len_i      (klen_q),
        .ptr_i      (kptr_q),
        .word_o     (kword),
        .ptr_next_o (kptr_nx)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_MIX;
            ST_MIX:    if (mix_last) state_d = ST_ENC;
            ST_ENC:    if (rnd_last) state_d = ct_q ? ST_CSTORE : ST_WRITE;
            ST_WRITE:  state_d = (blk_last && !last_expand) ? ST_MIX : ST_ENC;
            ST_CSTORE: if (crep_q == 6'(CT_REPS - 1) && cblk_q == 2'(CT_BLOCKS - 1))
                           state_d = ST_DONE;
                       else
                           state_d = ST_ENC;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            l_q <= '0; r_q <= '0; rnd_q <= '0; widx_q <= '0; kptr_q <= '0;
            blk_q <= '0; salted_q <= 1'b0; src_salt_q <= 1'b0; ct_q <= 1'b0;
            iter_q <= '0; cblk_q <= '0; crep_q <= '0; cost_q <= '0;
            salt_q <= '0; key_q <= '0; klen_q <= '0; res_q <= '0; err_q <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i && !in_ok) begin
                        err_q <= 1'b1;
                    end else if (accept) begin
                        cost_q     <= cost_i;
                        salt_q     <= salt_i;
                        key_q      <= key_i;
                        klen_q     <= klen_i;
                        salted_q   <= 1'b1;
                        src_salt_q <= 1'b0;
                        ct_q       <= 1'b0;
                        iter_q     <= 32'd1 << cost_i;
                        widx_q     <= '0;
                        kptr_q     <= '0;
                    end
                end
                ST_MIX: begin
                    widx_q <= widx_q + PW'(1);
                    kptr_q <= kptr_nx;
                    if (mix_last) begin
                        rnd_q <= '0;
                        blk_q <= '0;
                        {l_q, r_q} <= salted_q ? salt_q[127:64] : 64'h0;
                    end
                end
                ST_ENC: begin
                    l_q   <= l_nx;
                    r_q   <= r_nx;
                    rnd_q <= rnd_q + RW'(1);
                end
                ST_WRITE: begin
                    rnd_q <= '0;
                    if (!blk_last) begin
                        blk_q      <= blk_q + BW'(1);
                        {l_q, r_q} <= out_blk ^ half_nx;
                    end else begin
                        blk_q  <= '0;
                        widx_q <= '0;
                        kptr_q <= '0;
                        if (salted_q) begin
                            salted_q <= 1'b0;
                        end else if (!src_salt_q) begin
                            src_salt_q <= 1'b1;
                        end else if (iter_q == 32'd1) begin
                            ct_q       <= 1'b1;
                            cblk_q     <= '0;
                            crep_q     <= '0;
                            {l_q, r_q} <= ct_block(2'd0);
                        end else begin
                            iter_q     <= iter_q - 32'd1;
                            src_salt_q <= 1'b0;
                        end
                    end
                end
                ST_CSTORE: begin
                    rnd_q <= '0;
                    if (crep_q == 6'(CT_REPS - 1)) begin
                        res_q[(CT_BLOCKS - 1 - int'(cblk_q)) * 64 +: 64] <= out_blk;
                        crep_q     <= '0;
                        cblk_q     <= cblk_q + 2'd1;
                        {l_q, r_q} <= ct_block(cblk_q + 2'd1);
                    end else begin
                        crep_q     <= crep_q + 6'd1;
                        {l_q, r_q} <= out_blk;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        done_o   = (state_q == ST_DONE);
        err_o    = err_q;
        result_o = res_q;
        cost_o   = cost_q;
        salt_o   = salt_q;
    end

    AST_ERR_NO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_q |-> (state_q == ST_IDLE)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R10
    AST_ROUNDS_BEFORE_USE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_WRITE || state_q == ST_CSTORE) |->
        ($past(state_q) == ST_ENC && $past(rnd_q) == RW'(ROUNDS - 1))); // R5
    AST_MIX_COMPLETE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ENC && $past(state_q) == ST_MIX) |-> ($past(widx_q) == PW'(NP - 1))); // R4
    AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_MIX) |-> (kptr_q < (src_salt_q ? LW'(SALT_BYTES) : klen_q))); // R4
    AST_ITER_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_MIX) |-> (iter_q != 32'd0)); // R7
    AST_START_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_IDLE) |=> ($stable(key_q) && $stable(cost_q) && $stable(salt_q))); // R11
    AST_DONE_AFTER_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(state_q) == ST_CSTORE)); // R8

endmodule

// File: tb/bcx_keysched_tb.sv
module bcx_keysched_tb_top;

    localparam int R_T  = 16;
    localparam int IX_T = 3;
    localparam int KBY  = 72;
    localparam int NP   = R_T + 2;
    localparam int SN   = 1 << IX_T;
    localparam int NW   = NP + 4 * SN;
    localparam int NB   = NW / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [5:0]   cost = '0;
    logic [6:0]   klen = '0;
    logic [575:0] key = '0;
    logic [127:0] salt = '0;
    logic         done, err;
    logic [191:0] result;
    logic [5:0]   cost_q;
    logic [127:0] salt_q;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bcx_keysched #(.ROUNDS(R_T), .SBOX_IDX(IX_T), .KEY_BYTES(KBY)) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .start_i  (start),
        .cost_i   (cost),
        .klen_i   (klen),
        .key_i    (key),
        .salt_i   (salt),
        .done_o   (done),
        .err_o    (err),
        .result_o (result),
        .cost_o   (cost_q),
        .salt_o   (salt_q)
    );

    // ---------------- reference model ----------------
    logic [31:0] mw [NW];

    function automatic logic [31:0] ref_f(input logic [31:0] x);
        logic [31:0] s [4];
        for (int j = 0; j < 4; j++) begin
            int idx;
            idx  = int'((x >> (24 - 8 * j)) & 32'hFF) & (SN - 1);
            s[j] = mw[NP + j * SN + idx];
        end
        return ((s[0] + s[1]) ^ s[2]) + s[3];
    endfunction

    function automatic logic [63:0] ref_enc(input logic [63:0] blk);
        logic [31:0] l, r, t;
        l = blk[63:32];
        r = blk[31:0];
        for (int i = 0; i < R_T; i++) begin
            l = l ^ mw[i];
            r = r ^ ref_f(l);
            t = l; l = r; r = t;
        end
        t = l; l = r; r = t;
        r = r ^ mw[R_T];
        l = l ^ mw[R_T + 1];
        return {l, r};
    endfunction

    task automatic ref_expand(input bit salted, input bit use_salt,
                              input logic [575:0] k, input int kl, input logic [127:0] s);
        int pos, len;
        logic [63:0] blk;
        pos = 0;
        len = use_salt ? 16 : kl;
        for (int i = 0; i < NP; i++) begin
            logic [31:0] w;
            w = '0;
            for (int j = 0; j < 4; j++) begin
                logic [7:0] b;
                b   = use_salt ? s[127 - 8 * pos -: 8] : k[575 - 8 * pos -: 8];
                w   = {w[23:0], b};
                pos = (pos + 1) % len;
            end
            mw[i] = mw[i] ^ w;
        end
        blk = '0;
        for (int b = 0; b < NB; b++) begin
            if (salted) blk = blk ^ ((b % 2 == 0) ? s[127:64] : s[63:0]);
            blk = ref_enc(blk);
            mw[2 * b]     = blk[63:32];
            mw[2 * b + 1] = blk[31:0];
        end
    endtask

    task automatic ref_hash(input int c, input logic [575:0] k, input int kl,
                            input logic [127:0] s, output logic [191:0] res);
        logic [63:0] ct [3];
        ct[0] = 64'h4F7270686561_6E42;
        ct[1] = 64'h65686F6C64657253;
        ct[2] = 64'h637279446F756274;
        for (int i = 0; i < NW; i++) begin
            logic [31:0] kk;
            kk    = 32'(i) + 32'd1;
            mw[i] = (kk * 32'h9E3779B9) ^ 32'h243F6A88; // R3
        end
        ref_expand(1'b1, 1'b0, k, kl, s);
        for (int it = 0; it < (1 << c); it++) begin
            ref_expand(1'b0, 1'b0, k, kl, s); // R7 key first
            ref_expand(1'b0, 1'b1, k, kl, s);
        end
        for (int b = 0; b < 3; b++) begin
            logic [63:0] blk;
            blk = ct[b];
            for (int n = 0; n < 64; n++) blk = ref_enc(blk);
            res[191 - 64 * b -: 64] = blk;
        end
    endtask

    function automatic int exp_lat(input int c);
        return (1 + 2 * (1 << c)) * (NP + NB * (R_T + 1)) + 192 * (R_T + 1);
    endfunction

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string tag,
                         input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_run(input int c, input int kl, input logic [575:0] k,
                          input logic [127:0] s, input bit poke, output logic [191:0] got);
        logic [191:0] expv;
        int cyc;
        ref_hash(c, k, kl, s, expv);
        @(negedge clk);
        cost = 6'(c); klen = 7'(kl); key = k; salt = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        check(err == 1'b0, "R2 valid start no error", 192'(err), 192'(0));
        while (done !== 1'b1 && cyc < 70000) begin
            if (poke && cyc == 50) begin
                start = 1'b1; cost = 6'd5; klen = 7'd3; key = ~k; salt = ~s;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        check(cyc == exp_lat(c), "R9 latency", 192'(cyc), 192'(exp_lat(c)));
        check(result == expv, "R5/R6/R7/R8 hash result", result, expv);
        if (poke) check(result == expv, "R11 start during run ignored", result, expv);
        check(cost_q == 6'(c), "R10 cost echo", 192'(cost_q), 192'(c));
        check(salt_q == s, "R10 salt echo", 192'(salt_q), 192'(s));
        @(negedge clk);
        check(done == 1'b0, "R10 done single cycle", 192'(done), 192'(0));
        got = result;
    endtask

    task automatic bad_start(input int c, input int kl, input logic [191:0] prev);
        @(negedge clk);
        cost = 6'(c); klen = 7'(kl); salt = ~salt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err == 1'b1, "R2 err pulse", 192'(err), 192'(1));
        @(negedge clk);
        check(err == 1'b0, "R2 err one cycle", 192'(err), 192'(0));
        for (int i = 0; i < 4; i++) begin
            check(done == 1'b0, "R2 no run after reject", 192'(done), 192'(0));
            @(negedge clk);
        end
        check(result == prev, "R2 result kept", result, prev);
    endtask

    initial begin
        logic [575:0] k;
        logic [127:0] s;
        logic [191:0] res_a, res_tmp;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1 done after reset", 192'(done), 192'(0));
        check(err == 1'b0, "R1 err after reset", 192'(err), 192'(0));
        check(result == '0, "R1 result after reset", result, 192'(0));

        // Directed: one-byte key, cost at lower bound
        for (int w = 0; w < 18; w++) k[w * 32 +: 32] = $urandom;
        s = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
        do_run(4, 1, k, s, 1'b0, res_a);

        // Rejections at each edge of the legal range
        bad_start(3, 10, res_a);
        bad_start(32, 10, res_a);
        bad_start(63, 10, res_a);
        bad_start(4, 0, res_a);
        bad_start(4, 73, res_a);

        // Full-length key with a start pulse in the middle
        for (int w = 0; w < 18; w++) k[w * 32 +: 32] = $urandom;
        for (int w = 0; w < 4; w++) s[w * 32 +: 32] = $urandom;
        do_run(4, 72, k, s, 1'b1, res_tmp);

        // Random mid-length key at a higher cost
        for (int w = 0; w < 18; w++) k[w * 32 +: 32] = $urandom;
        for (int w = 0; w < 4; w++) s[w * 32 +: 32] = $urandom;
        do_run(5, 2 + int'($urandom % 69), k, s, 1'b0, res_tmp);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule